// File: doc/BRIEF.md
# Byte-Lane Write-Masked Register Bank

This block is an APB4 completer that holds a small bank of data-width registers. A write merges into the addressed register only those byte lanes whose write-strobe bit is set; the other bytes keep what they held, so software can change one field of a word without first reading it back. A read returns the whole stored word.

A transfer is a setup phase (`psel`=1, `penable`=0) followed by one access phase (`psel`=1, `penable`=1). `pready` is always high, so the block applies no back-pressure: every access phase completes in that cycle, and the register update lands on the clock edge that closes it. The requester may not hold a transfer open, and no flow of data is buffered on either side.

The address must be aligned to the bus width and must fall on a mapped register. Otherwise the block answers with an error and leaves every register untouched. The data width, the address width and the register count are parameters. The strobe width is the data width divided by eight.

Top module: `byte_lane_regbank`

## Requirements
- R1: After `presetn` is low, every register reads back as zero.
- R2: On an accepted write, strobe bit n set copies `pwdata[8n+7:8n]` into the same byte of the addressed register. Bit 0 selects the least significant byte.
- R3: On an accepted write, a byte whose strobe bit is 0 keeps its previous value.
- R4: A write with every strobe bit 0 completes without error and changes no register.
- R5: A register changes only on the clock edge that ends an access phase. A setup phase that is not followed by an access phase changes nothing.
- R6: An access whose low address bits (`paddr[1:0]` for 32-bit data) are not zero raises `pslverr` in the access phase. It modifies no register and returns `prdata` = 0.
- R7: An aligned access whose word index `paddr[ADDR_W-1:2]` is not below `NUM_REGS` raises `pslverr` in the access phase. It modifies no register and does not alias onto a mapped register.
- R8: A read access returns the full stored word at word index `paddr[ADDR_W-1:2]` in the access phase. The strobe value has no effect on a read.
- R9: `pready` is 1 in every cycle.
- R10: Outside an access phase, `pslverr` is 0 and `prdata` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus clock |
| presetn | input | 1 | Asynchronous reset, active low |
| psel | input | 1 | Completer selected |
| penable | input | 1 | Access phase marker |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | ADDR_W | Byte address |
| pwdata | input | DATA_W | Write data |
| pstrb | input | DATA_W/8 | Byte-lane write enables |
| prdata | output | DATA_W | Read data, valid in a read access phase |
| pready | output | 1 | Transfer complete, always high |
| pslverr | output | 1 | Error response for misaligned or unmapped address |

## Verification
The properties assume that each transfer follows the APB4 sequence. `penable` rises only after a cycle of `psel` with `penable` low, and address, write flag, data and strobes stay stable from setup through access. The stimulus tasks always drive a full setup phase and then one access phase, and change the bus only one time unit after a rising edge. The only departure from the sequence is a deliberate setup phase that is dropped before its access phase, which exercises R5. A behavioural reference model of the bank is compared against `prdata` and `pslverr` on every clock.

// File: rtl/regbank_pkg.sv
package regbank_pkg;

  localparam int LANE_W = 8;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_SETUP = 2'd1,
    PH_READ  = 2'd2,
    PH_WRITE = 2'd3
  } bus_phase_e;

endpackage

// File: rtl/bus_phase_decode.sv
module bus_phase_decode
  import regbank_pkg::*;
(
  input  logic       sel,
  input  logic       enable,
  input  logic       write,
  output bus_phase_e phase
);

  always_comb begin
    if (!sel)        phase = PH_IDLE;
    else if (!enable) phase = PH_SETUP;
    else if (write)  phase = PH_WRITE;
    else             phase = PH_READ;
  end

endmodule

// File: rtl/addr_guard.sv
module addr_guard #(
  parameter int ADDR_W   = 6,
  parameter int DATA_W   = 32,
  parameter int NUM_REGS = 8,
  localparam int STRB_W  = DATA_W / 8,
  localparam int LSB     = (STRB_W > 1) ? $clog2(STRB_W) : 0,
  localparam int IDX_W   = ADDR_W - LSB
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [IDX_W-1:0]  index,
  output logic              misaligned,
  output logic              unmapped
);

  localparam logic [IDX_W:0] LIMIT = (IDX_W+1)'(NUM_REGS);

  assign index = addr[ADDR_W-1:LSB];

  generate
    if (LSB > 0) begin : g_low_bits
      assign misaligned = |addr[LSB-1:0];
    end else begin : g_byte_bus
      assign misaligned = 1'b0;
    end
  endgenerate

  assign unmapped = ({1'b0, index} >= LIMIT);

endmodule

// File: rtl/lane_merge.sv
module lane_merge
  import regbank_pkg::*;
#(
  parameter int DATA_W  = 32,
  localparam int STRB_W = DATA_W / LANE_W
) (
  input  logic [DATA_W-1:0] old_word,
  input  logic [DATA_W-1:0] new_word,
  input  logic [STRB_W-1:0] strb,
  output logic [DATA_W-1:0] merged
);

  generate
    for (genvar n = 0; n < STRB_W; n++) begin : g_lane
      assign merged[n*LANE_W +: LANE_W] =
        strb[n] ? new_word[n*LANE_W +: LANE_W] : old_word[n*LANE_W +: LANE_W];
    end
  endgenerate

endmodule

// File: rtl/reg_store.sv
module reg_store #(
  parameter int DATA_W   = 32,
  parameter int NUM_REGS = 8,
  parameter int IDX_W    = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       we,
  input  logic [IDX_W-1:0]           idx,
  input  logic [DATA_W-1:0]          wdata,
  output logic [DATA_W-1:0]          rdata,
  output logic [NUM_REGS*DATA_W-1:0] flat
);

  logic [DATA_W-1:0] mem [NUM_REGS];

  generate
    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          mem[i] <= '0;
        end else if (we && (idx == IDX_W'(i))) begin
          mem[i] <= wdata;
        end
      end
      assign flat[i*DATA_W +: DATA_W] = mem[i];
    end
  endgenerate

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (idx == IDX_W'(i)) rdata = mem[i];
    end
  end

endmodule

// File: rtl/byte_lane_regbank.sv
module byte_lane_regbank
  import regbank_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 6,
  parameter int NUM_REGS = 8,
  localparam int STRB_W  = DATA_W / 8,
  localparam int LSB     = (STRB_W > 1) ? $clog2(STRB_W) : 0,
  localparam int IDX_W   = ADDR_W - LSB
) (
  input  logic              pclk,
  input  logic              presetn,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DATA_W-1:0] pwdata,
  input  logic [STRB_W-1:0] pstrb,
  output logic [DATA_W-1:0] prdata,
  output logic              pready,
  output logic              pslverr
);

  bus_phase_e                 phase;
  logic [IDX_W-1:0]           index;
  logic                       misaligned;
  logic                       unmapped;
  logic                       bad_addr;
  logic                       commit;
  logic [DATA_W-1:0]          stored;
  logic [DATA_W-1:0]          merged;
  logic [NUM_REGS*DATA_W-1:0] mem_flat;

  bus_phase_decode u_phase (
    .sel    (psel),
    .enable (penable),
    .write  (pwrite),
    .phase  (phase)
  );

  addr_guard #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .NUM_REGS (NUM_REGS)
  ) u_guard (
    .addr       (paddr),
    .index      (index),
    .misaligned (misaligned),
    .unmapped   (unmapped)
  );

  assign bad_addr = misaligned | unmapped;
  assign commit   = (phase == PH_WRITE) && !bad_addr;

  lane_merge #(.DATA_W(DATA_W)) u_merge (
    .old_word (stored),
    .new_word (pwdata),
    .strb     (pstrb),
    .merged   (merged)
  );

  reg_store #(
    .DATA_W   (DATA_W),
    .NUM_REGS (NUM_REGS),
    .IDX_W    (IDX_W)
  ) u_store (
    .clk   (pclk),
    .rst_n (presetn),
    .we    (commit),
    .idx   (index),
    .wdata (merged),
    .rdata (stored),
    .flat  (mem_flat)
  );

  assign pready  = 1'b1;
  assign pslverr = ((phase == PH_READ) || (phase == PH_WRITE)) && bad_addr;
  assign prdata  = ((phase == PH_READ) && !bad_addr) ? stored : '0;

endmodule

// File: rtl/regbank_props.sv
module regbank_props #(
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 6,
  parameter int NUM_REGS = 8,
  localparam int STRB_W  = DATA_W / 8,
  localparam int LSB     = (STRB_W > 1) ? $clog2(STRB_W) : 0
) (
  input logic                       pclk,
  input logic                       presetn,
  input logic                       psel,
  input logic                       penable,
  input logic                       pwrite,
  input logic [ADDR_W-1:0]          paddr,
  input logic [STRB_W-1:0]          pstrb,
  input logic [DATA_W-1:0]          prdata,
  input logic                       pslverr,
  input logic [NUM_REGS*DATA_W-1:0] mem_flat
);

  localparam logic [ADDR_W-1:0] LOW_MASK = ADDR_W'((1 << LSB) - 1);

  logic access, low_bad, beyond;
  assign access  = psel && penable;
  assign low_bad = (paddr & LOW_MASK) != '0;
  assign beyond  = ((ADDR_W+1)'(paddr >> LSB)) >= (ADDR_W+1)'(NUM_REGS);

  // R6
  misalign_err_chk: assert property (@(posedge pclk) disable iff (!presetn)
    (access && low_bad) |-> (pslverr && prdata == '0));

  // R7
  unmapped_err_chk: assert property (@(posedge pclk) disable iff (!presetn)
    (access && !low_bad && beyond) |-> pslverr);

  // R10
  idle_quiet_chk: assert property (@(posedge pclk) disable iff (!presetn)
    !access |-> (!pslverr && prdata == '0));

  // R6
  error_hold_chk: assert property (@(posedge pclk) disable iff (!presetn)
    (access && pslverr) |=> $stable(mem_flat));

  // R4
  empty_strobe_chk: assert property (@(posedge pclk) disable iff (!presetn)
    (access && pwrite && pstrb == '0) |=> $stable(mem_flat));

  // R5
  no_access_hold_chk: assert property (@(posedge pclk) disable iff (!presetn)
    !(access && pwrite) |=> $stable(mem_flat));

endmodule

bind byte_lane_regbank regbank_props #(
  .DATA_W   (DATA_W),
  .ADDR_W   (ADDR_W),
  .NUM_REGS (NUM_REGS)
) u_props (
  .pclk     (pclk),
  .presetn  (presetn),
  .psel     (psel),
  .penable  (penable),
  .pwrite   (pwrite),
  .paddr    (paddr),
  .pstrb    (pstrb),
  .prdata   (prdata),
  .pslverr  (pslverr),
  .mem_flat (mem_flat)
);

// File: tb/sim_byte_lane_regbank.sv
module sim_byte_lane_regbank;

  localparam int CLK_PERIOD = 10;
  localparam int DW = 32;
  localparam int AW = 6;
  localparam int NR = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [AW-1:0] paddr = '0;
  logic [DW-1:0] pwdata = '0;
  logic [3:0]    pstrb = '0;
  logic [DW-1:0] prdata;
  logic          pready, pslverr;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  logic [DW-1:0] model [NR];

  always #(CLK_PERIOD/2) clk = ~clk;

  byte_lane_regbank #(.DATA_W(DW), .ADDR_W(AW), .NUM_REGS(NR)) u0 (
    .pclk(clk), .presetn(rst_n), .psel(psel), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .pstrb(pstrb),
    .prdata(prdata), .pready(pready), .pslverr(pslverr)
  );

  function automatic logic [DW-1:0] lanes(logic [DW-1:0] o, logic [DW-1:0] d, logic [3:0] s);
    logic [DW-1:0] r = o;
    for (int b = 0; b < 4; b++) if (s[b]) r[8*b +: 8] = d[8*b +: 8];
    return r;
  endfunction

  task automatic chk(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // per-cycle reference comparison
  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic acc, err;
      int idx;
      logic [DW-1:0] exp_rd;
      acc = psel && penable;
      idx = int'(paddr >> 2);
      err = acc && ((paddr[1:0] != 2'b00) || idx >= NR);
      exp_rd = (acc && !pwrite && !err) ? model[idx] : '0;
      chk("R9 pready", {31'b0, pready}, 32'd1);
      if (!acc) begin
        chk("R10 idle pslverr", {31'b0, pslverr}, 32'd0);
        chk("R10 idle prdata", prdata, 32'd0);
      end else begin
        chk(err ? "R6/R7 pslverr" : "R8 pslverr", {31'b0, pslverr}, {31'b0, err});
        chk(pwrite ? "R10 write prdata" : "R8 read data", prdata, exp_rd);
        if (pwrite && !err) model[idx] = lanes(model[idx], pwdata, pstrb);
      end
    end
  end

  task automatic xfer(input logic wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                      input logic [3:0] s, output logic [DW-1:0] rd, output logic er);
    @(posedge clk); #1;
    psel = 1; penable = 0; pwrite = wr; paddr = a; pwdata = d; pstrb = s;
    @(posedge clk); #1;
    penable = 1;
    @(negedge clk);
    rd = prdata; er = pslverr;
    @(posedge clk); #1;
    psel = 0; penable = 0;
  endtask

  task automatic rd_chk(string req, logic [AW-1:0] a, logic [DW-1:0] exp, logic [3:0] s = 4'h0);
    logic [DW-1:0] r; logic e;
    xfer(1'b0, a, '0, s, r, e);
    chk(req, r, exp);
  endtask

  task automatic wr(logic [AW-1:0] a, logic [DW-1:0] d, logic [3:0] s, output logic er);
    logic [DW-1:0] r;
    xfer(1'b1, a, d, s, r, er);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic er;
    logic [DW-1:0] acc5;
    for (int i = 0; i < NR; i++) model[i] = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    // R1: all registers zero after reset
    for (int i = 0; i < NR; i++) rd_chk("R1 reset value", AW'(4*i), 32'h0);

    // R2: full and single-lane writes
    wr(6'h00, 32'h11223344, 4'b1111, er);
    rd_chk("R2 full word", 6'h00, 32'h11223344);
    wr(6'h04, 32'hAABBCCDD, 4'b0001, er);
    rd_chk("R2 lane 0 only", 6'h04, 32'h000000DD);
    wr(6'h04, 32'h55667788, 4'b1000, er);
    rd_chk("R2 lane 3 only", 6'h04, 32'h550000DD);

    // R3: middle lanes only
    wr(6'h00, 32'hFFFFFFFF, 4'b0110, er);
    rd_chk("R3 untouched lanes", 6'h00, 32'h11FFFF44);

    // R4: empty strobe
    wr(6'h00, 32'hDEADBEEF, 4'b0000, er);
    chk("R4 no error", {31'b0, er}, 32'd0);
    rd_chk("R4 unchanged", 6'h00, 32'h11FFFF44);

    // R5: setup phase dropped before access
    @(posedge clk); #1;
    psel = 1; penable = 0; pwrite = 1; paddr = 6'h08; pwdata = 32'hCAFEF00D; pstrb = 4'hF;
    @(negedge clk);
    chk("R10 setup prdata", prdata, 32'h0);
    @(posedge clk); #1;
    psel = 0;
    rd_chk("R5 aborted setup", 6'h08, 32'h0);

    // R6: misaligned
    wr(6'h05, 32'h12345678, 4'hF, er);
    chk("R6 write pslverr", {31'b0, er}, 32'd1);
    rd_chk("R6 reg1 unchanged", 6'h04, 32'h550000DD);
    begin
      logic [DW-1:0] r; logic e;
      xfer(1'b0, 6'h02, '0, 4'h0, r, e);
      chk("R6 read pslverr", {31'b0, e}, 32'd1);
      chk("R6 read data zero", r, 32'h0);
    end

    // R7: unmapped, would alias onto reg1 if index wrapped
    wr(6'h24, 32'h87654321, 4'hF, er);
    chk("R7 pslverr", {31'b0, er}, 32'd1);
    rd_chk("R7 no alias reg1", 6'h04, 32'h550000DD);
    rd_chk("R7 reg0 intact", 6'h00, 32'h11FFFF44);
    begin
      logic [DW-1:0] r; logic e;
      xfer(1'b0, 6'h3C, '0, 4'h0, r, e);
      chk("R7 read pslverr", {31'b0, e}, 32'd1);
    end

    // R8: strobe ignored on read, top register
    wr(6'h1C, 32'h0BADC0DE, 4'hF, er);
    rd_chk("R8 read strobe 0", 6'h1C, 32'h0BADC0DE, 4'h0);
    rd_chk("R8 read strobe F", 6'h1C, 32'h0BADC0DE, 4'hF);

    // R2/R3: sweep of every strobe pattern on reg5
    acc5 = '0;
    for (int s = 0; s < 16; s++) begin
      logic [DW-1:0] d;
      d = 32'h01010101 * (s + 1) ^ 32'hA5C30F96;
      wr(6'h14, d, 4'(s), er);
      acc5 = lanes(acc5, d, 4'(s));
      rd_chk("R3 strobe sweep", 6'h14, acc5);
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule